// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical pixel counters of a raster display and derives from them the active-video window, the two sync pulses and an early-line prefetch strobe. A simple register write port sets every limit. Each limit is written as its count minus one, so a line of 1344 pixels is programmed as 1343. Software normally clears the run bits, loads a new mode and then sets the run bits again.

The sync outputs can be inverted one at a time, and three power-saving controls hold them idle: one for the horizontal pulse, one for the vertical pulse and one for both. A separate display-off control forces the video window low and raises a blank flag while the syncs keep running. A sync-on-RGB bit is passed out as a flag for the video path. Limit registers are double-buffered. While the generator runs, new values wait for the next frame boundary, so a half-written mode never produces a runt line.

All outputs are registered and aligned with each other. The values on `hcount_o` and `vcount_o` are the coordinates to which `de_o`, `hsync_o`, `vsync_o` and `prefetch_o` in the same cycle refer.

Top module: `rtg_top`

## Requirements
- R1: While reset is high and in the first cycle after it falls, every output is 0.
- R2: While control register (address 0) bit 0 is 0, both counters stay at 0 and de_o and prefetch_o stay low.
- R3: While running, hcount_o steps by one each clock from 0 up to the line-total register (address 4) and then returns to 0. At that return vcount_o steps by one, and it returns to 0 after the frame-total register (address 8).
- R4: de_o is high exactly when the generator runs, control bit 1 (refresh) is set, the display-off bit is clear, hcount_o is at most the register at address 5 and vcount_o is at most the register at address 9.
- R5: Before inversion and gating, hsync is active when hcount_o is greater than the register at address 6 and at most the register at address 7.
- R6: Before inversion and gating, vsync is active when vcount_o is greater than the register at address 10 and at most the register at address 11.
- R7: prefetch_o is high for one clock on every line, when hcount_o equals the register at address 12, so a line gives exactly one pulse.
- R8: In the sync register (address 1), bit 3 inverts hsync_o and bit 4 inverts vsync_o.
- R9: Sync register bit 5 holds hsync_o at its inactive level and bit 6 does the same for vsync_o. Bit 1 holds both. The inactive level is the value of the matching invert bit.
- R10: Display register (address 2) bit 1 sets blank_o high and forces de_o low. The counters and syncs keep running.
- R11: A limit register written while running takes effect at the next frame start. A limit written while stopped is in force as soon as the generator starts.
- R12: Sync register bit 0 appears on sync_rgb_o and has no effect on the sync outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | CW | Register write data |
| hcount_o | output | CW | Horizontal pixel counter |
| vcount_o | output | CW | Vertical line counter |
| de_o | output | 1 | Active-video window |
| hsync_o | output | 1 | Horizontal sync after inversion and gating |
| vsync_o | output | 1 | Vertical sync after inversion and gating |
| prefetch_o | output | 1 | One-clock early-line strobe |
| blank_o | output | 1 | Display forced off |
| sync_rgb_o | output | 1 | Sync-on-RGB flag |

## Verification
The properties assume a consistent mode. The line total is at least two pixels, so a prefetch pulse can never repeat on consecutive clocks. Each display and sync limit also lies inside its total. The stimulus loads only such modes: a 10- or 12-pixel line, a 6-line frame, and sync windows well inside both. It writes only the mapped addresses and changes the sync and display controls only while the generator runs on a mode it has already loaded.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // limit slots, in the order their addresses follow A_LIM0
  localparam int NLIM    = 9;
  localparam int L_HTOT  = 0;
  localparam int L_HDISP = 1;
  localparam int L_HSS   = 2;
  localparam int L_HSE   = 3;
  localparam int L_VTOT  = 4;
  localparam int L_VDISP = 5;
  localparam int L_VSS   = 6;
  localparam int L_VSE   = 7;
  localparam int L_SHORT = 8;

  // register addresses
  localparam int A_CTRL = 0;
  localparam int A_SYNC = 1;
  localparam int A_DISP = 2;
  localparam int A_LIM0 = 4;

  // bit positions
  localparam int C_EN     = 0;
  localparam int C_REFR   = 1;
  localparam int S_RGB    = 0;
  localparam int S_ALLOFF = 1;
  localparam int S_HINV   = 3;
  localparam int S_VINV   = 4;
  localparam int S_HOFF   = 5;
  localparam int S_VOFF   = 6;
  localparam int D_OFF    = 1;

  typedef struct packed {
    logic rgb;
    logic all_off;
    logic h_inv;
    logic v_inv;
    logic h_off;
    logic v_off;
  } sync_cfg_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int AW = 4,
  parameter int CW = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [CW-1:0]             wr_data,
  input  logic                      wrap,
  output logic                      en_o,
  output logic                      refresh_o,
  output logic                      disp_off_o,
  output sync_cfg_t                 sync_o,
  output logic [NLIM-1:0][CW-1:0]   lim_o
);
  logic [NLIM-1:0][CW-1:0] pend_q;
  logic                    load;

  // active set follows the pending set while stopped, else only at frame wrap
  assign load = !en_o || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o       <= 1'b0;
      refresh_o  <= 1'b0;
      disp_off_o <= 1'b0;
      sync_o     <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CTRL)) begin
        en_o      <= wr_data[C_EN];
        refresh_o <= wr_data[C_REFR];
      end
      if (wr_addr == AW'(A_SYNC)) begin
        sync_o.rgb     <= wr_data[S_RGB];
        sync_o.all_off <= wr_data[S_ALLOFF];
        sync_o.h_inv   <= wr_data[S_HINV];
        sync_o.v_inv   <= wr_data[S_VINV];
        sync_o.h_off   <= wr_data[S_HOFF];
        sync_o.v_off   <= wr_data[S_VOFF];
      end
      if (wr_addr == AW'(A_DISP))
        disp_off_o <= wr_data[D_OFF];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      lim_o  <= '0;
    end else begin
      for (int i = 0; i < NLIM; i++) begin
        if (wr_en && wr_addr == AW'(A_LIM0 + i))
          pend_q[i] <= wr_data;
        if (load)
          lim_o[i] <= pend_q[i];
      end
    end
  end
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] htot,
  input  logic [CW-1:0] vtot,
  output logic [CW-1:0] h_o,
  output logic [CW-1:0] v_o,
  output logic          wrap_o
);
  logic h_end;

  assign h_end  = (h_o == htot);
  assign wrap_o = en && h_end && (v_o == vtot);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      h_o <= '0;
      v_o <= '0;
    end else if (h_end) begin
      h_o <= '0;
      v_o <= (v_o == vtot) ? '0 : v_o + CW'(1);
    end else begin
      h_o <= h_o + CW'(1);
    end
  end
endmodule

// File: rtl/rtg_outstage.sv
module rtg_outstage
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          refresh,
  input  logic          disp_off,
  input  sync_cfg_t     cfg,
  input  logic [CW-1:0] h,
  input  logic [CW-1:0] v,
  input  logic [CW-1:0] hdisp,
  input  logic [CW-1:0] vdisp,
  input  logic [CW-1:0] hss,
  input  logic [CW-1:0] hse,
  input  logic [CW-1:0] vss,
  input  logic [CW-1:0] vse,
  input  logic [CW-1:0] short_cmp,
  output logic [CW-1:0] hcount_o,
  output logic [CW-1:0] vcount_o,
  output logic          de_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          prefetch_o,
  output logic          blank_o,
  output logic          sync_rgb_o
);
  localparam int NCH = 2;   // channel 0 horizontal, 1 vertical

  logic [NCH-1:0][CW-1:0] pos, s_beg, s_fin;
  logic [NCH-1:0]         raw, kill, inv, nxt;
  logic                   de_d, pf_d;

  assign pos[0]   = h;
  assign pos[1]   = v;
  assign s_beg[0] = hss;
  assign s_beg[1] = vss;
  assign s_fin[0] = hse;
  assign s_fin[1] = vse;
  assign kill     = {cfg.all_off | cfg.v_off, cfg.all_off | cfg.h_off};
  assign inv      = {cfg.v_inv, cfg.h_inv};

  for (genvar c = 0; c < NCH; c++) begin : g_sync
    assign raw[c] = en && (pos[c] > s_beg[c]) && (pos[c] <= s_fin[c]);
    assign nxt[c] = (raw[c] && !kill[c]) ^ inv[c];
  end

  assign de_d = en && refresh && !disp_off && (h <= hdisp) && (v <= vdisp);
  assign pf_d = en && (h == short_cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcount_o   <= '0;
      vcount_o   <= '0;
      de_o       <= 1'b0;
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      prefetch_o <= 1'b0;
      blank_o    <= 1'b0;
      sync_rgb_o <= 1'b0;
    end else begin
      hcount_o   <= h;
      vcount_o   <= v;
      de_o       <= de_d;
      hsync_o    <= nxt[0];
      vsync_o    <= nxt[1];
      prefetch_o <= pf_d;
      blank_o    <= disp_off;
      sync_rgb_o <= cfg.rgb;
    end
  end
endmodule

// File: rtl/rtg_top.sv
module rtg_top
  import rtg_pkg::*;
#(
  parameter int AW = 4,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] hcount_o,
  output logic [CW-1:0] vcount_o,
  output logic          de_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          prefetch_o,
  output logic          blank_o,
  output logic          sync_rgb_o
);
  logic                    ctl_en, ctl_refresh, disp_off, wrap;
  sync_cfg_t               sync_cfg;
  logic [NLIM-1:0][CW-1:0] lim_act;
  logic [CW-1:0]           h_cnt, v_cnt, hdisp_a, vdisp_a;

  assign hdisp_a = lim_act[L_HDISP];
  assign vdisp_a = lim_act[L_VDISP];

  rtg_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wrap(wrap), .en_o(ctl_en), .refresh_o(ctl_refresh), .disp_off_o(disp_off),
    .sync_o(sync_cfg), .lim_o(lim_act)
  );

  rtg_counters #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(ctl_en),
    .htot(lim_act[L_HTOT]), .vtot(lim_act[L_VTOT]),
    .h_o(h_cnt), .v_o(v_cnt), .wrap_o(wrap)
  );

  rtg_outstage #(.CW(CW)) u_out (
    .clk(clk), .rst(rst), .en(ctl_en), .refresh(ctl_refresh), .disp_off(disp_off),
    .cfg(sync_cfg), .h(h_cnt), .v(v_cnt), .hdisp(hdisp_a), .vdisp(vdisp_a),
    .hss(lim_act[L_HSS]), .hse(lim_act[L_HSE]),
    .vss(lim_act[L_VSS]), .vse(lim_act[L_VSE]), .short_cmp(lim_act[L_SHORT]),
    .hcount_o(hcount_o), .vcount_o(vcount_o), .de_o(de_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .prefetch_o(prefetch_o), .blank_o(blank_o),
    .sync_rgb_o(sync_rgb_o)
  );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          h_off,
  input logic          all_off,
  input logic          h_inv,
  input logic [CW-1:0] hdisp,
  input logic [CW-1:0] vdisp,
  input logic [CW-1:0] hcount,
  input logic [CW-1:0] vcount,
  input logic          de,
  input logic          blank,
  input logic          prefetch,
  input logic          hsync
);
  assert_hcount_step_R3: assert property (@(posedge clk) disable iff (rst)
    (hcount != '0) |-> (hcount == CW'($past(hcount) + CW'(1))));

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && !$past(en, 2)) |-> (hcount == '0 && vcount == '0 && !prefetch));

  assert_de_window_R4: assert property (@(posedge clk) disable iff (rst)
    de |-> (hcount <= $past(hdisp) && vcount <= $past(vdisp)));

  assert_blank_no_de_R10: assert property (@(posedge clk) disable iff (rst)
    blank |-> !de);

  assert_prefetch_single_R7: assert property (@(posedge clk) disable iff (rst)
    prefetch |=> !prefetch);

  assert_hsync_held_R9: assert property (@(posedge clk) disable iff (rst)
    $past(h_off || all_off) |-> (hsync == $past(h_inv)));
endmodule

bind rtg_top rtg_checker #(.CW(CW)) u_rtg_checker (
  .clk(clk), .rst(rst), .en(ctl_en), .h_off(sync_cfg.h_off),
  .all_off(sync_cfg.all_off), .h_inv(sync_cfg.h_inv),
  .hdisp(hdisp_a), .vdisp(vdisp_a), .hcount(hcount_o), .vcount(vcount_o),
  .de(de_o), .blank(blank_o), .prefetch(prefetch_o), .hsync(hsync_o)
);

// File: tb/rtg_top_bench.sv
module rtg_top_bench;
  import rtg_pkg::*;
  localparam int AW = 4;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] hcount_o, vcount_o;
  logic          de_o, hsync_o, vsync_o, prefetch_o, blank_o, sync_rgb_o;

  rtg_top #(.AW(AW), .CW(CW)) u_rtg_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hcount_o(hcount_o), .vcount_o(vcount_o), .de_o(de_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .prefetch_o(prefetch_o), .blank_o(blank_o),
    .sync_rgb_o(sync_rgb_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // bench model of the programmed mode
  int m_ht = 9, m_hd = 5, m_hss = 6, m_hse = 8;
  int m_vt = 5, m_vd = 3, m_vss = 3, m_vse = 4, m_sh = 7;
  bit m_en = 0, m_refr = 0, m_off = 0;
  bit m_rgb = 0, m_all = 0, m_hinv = 0, m_vinv = 0, m_hoff = 0, m_voff = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = AW'(a);
    wr_data = CW'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic put_sync();
    wr(A_SYNC, (int'(m_rgb) << S_RGB) | (int'(m_all) << S_ALLOFF) |
               (int'(m_hinv) << S_HINV) | (int'(m_vinv) << S_VINV) |
               (int'(m_hoff) << S_HOFF) | (int'(m_voff) << S_VOFF));
    repeat (3) @(negedge clk);
  endtask

  task automatic put_ctrl(input bit en, input bit refr);
    m_en = en;
    m_refr = refr;
    wr(A_CTRL, (int'(refr) << C_REFR) | (int'(en) << C_EN));
    repeat (3) @(negedge clk);
  endtask

  task automatic load_mode();
    wr(A_LIM0 + L_HTOT, m_ht);   wr(A_LIM0 + L_HDISP, m_hd);
    wr(A_LIM0 + L_HSS, m_hss);   wr(A_LIM0 + L_HSE, m_hse);
    wr(A_LIM0 + L_VTOT, m_vt);   wr(A_LIM0 + L_VDISP, m_vd);
    wr(A_LIM0 + L_VSS, m_vss);   wr(A_LIM0 + L_VSE, m_vse);
    wr(A_LIM0 + L_SHORT, m_sh);
  endtask

  // sample every cycle and compare all outputs against the model
  task automatic watch(input int ncyc, output int pf_cnt, output int hmax);
    int ph, pv, h, v, eh, ev;
    bit ehs, evs;
    pf_cnt = 0;
    hmax = 0;
    ph = 0;
    pv = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      h = int'(hcount_o);
      v = int'(vcount_o);
      if (h > hmax) hmax = h;
      if (prefetch_o) pf_cnt++;
      if (!m_en) begin
        eh = 0; ev = 0;
        chk("R2 hcount idle", h, eh);
        chk("R2 vcount idle", v, ev);
      end else if (i > 0) begin
        eh = (ph == m_ht) ? 0 : ph + 1;
        ev = (ph == m_ht) ? ((pv == m_vt) ? 0 : pv + 1) : pv;
        chk("R3 hcount", h, eh);
        chk("R3 vcount", v, ev);
      end
      ehs = ((m_en && h > m_hss && h <= m_hse) && !(m_all || m_hoff)) ^ m_hinv;
      evs = ((m_en && v > m_vss && v <= m_vse) && !(m_all || m_voff)) ^ m_vinv;
      chk("R4 de", int'(de_o), int'(m_en && m_refr && !m_off && h <= m_hd && v <= m_vd));
      chk("R5/R8/R9 hsync", int'(hsync_o), int'(ehs));
      chk("R6/R8/R9 vsync", int'(vsync_o), int'(evs));
      chk("R7 prefetch", int'(prefetch_o), int'(m_en && h == m_sh));
      chk("R10 blank", int'(blank_o), int'(m_off));
      chk("R12 sync_rgb", int'(sync_rgb_o), int'(m_rgb));
      ph = h;
      pv = v;
    end
  endtask

  task automatic t_reset();
    chk("R1 hcount", int'(hcount_o), 0);
    chk("R1 vcount", int'(vcount_o), 0);
    chk("R1 de", int'(de_o), 0);
    chk("R1 hsync", int'(hsync_o), 0);
    chk("R1 vsync", int'(vsync_o), 0);
    chk("R1 prefetch", int'(prefetch_o), 0);
    chk("R1 blank", int'(blank_o), 0);
    chk("R1 sync_rgb", int'(sync_rgb_o), 0);
  endtask

  task automatic t_idle();
    int pf, hm;
    load_mode();
    watch(20, pf, hm);
    chk("R2 no prefetch while stopped", pf, 0);
  endtask

  task automatic t_run();
    int pf, hm;
    put_ctrl(1, 1);
    watch(120, pf, hm);
    chk("R7 one pulse per line over two frames", pf, 12);
    chk("R3 line maximum", hm, m_ht);
    put_ctrl(1, 0);
    watch(60, pf, hm);
    put_ctrl(1, 1);
  endtask

  task automatic t_polarity();
    int pf, hm;
    m_hinv = 1; m_vinv = 1;
    put_sync();
    watch(60, pf, hm);
    m_hinv = 0; m_vinv = 0;
    put_sync();
  endtask

  task automatic t_sync_off();
    int pf, hm;
    m_hoff = 1; m_hinv = 1;
    put_sync();
    watch(60, pf, hm);
    m_hoff = 0; m_hinv = 0; m_voff = 1;
    put_sync();
    watch(60, pf, hm);
    m_voff = 0; m_all = 1; m_hinv = 1; m_vinv = 1;
    put_sync();
    watch(60, pf, hm);
    m_all = 0; m_hinv = 0; m_vinv = 0;
    put_sync();
  endtask

  task automatic t_rgb();
    int pf, hm;
    m_rgb = 1;
    put_sync();
    watch(60, pf, hm);
    m_rgb = 0;
    put_sync();
  endtask

  task automatic t_blank();
    int pf, hm;
    m_off = 1;
    wr(A_DISP, 1 << D_OFF);
    repeat (3) @(negedge clk);
    watch(60, pf, hm);
    m_off = 0;
    wr(A_DISP, 0);
    repeat (3) @(negedge clk);
    watch(20, pf, hm);
  endtask

  task automatic t_shadow();
    int pf, hm, guard, seen;
    guard = 0;
    while (int'(vcount_o) != 1 && guard < 200) begin
      @(negedge clk); guard++;
    end
    wr(A_LIM0 + L_HTOT, 11);
    seen = 0;
    guard = 0;
    while (!(vcount_o == '0 && hcount_o == '0) && guard < 200) begin
      if (int'(hcount_o) > seen) seen = int'(hcount_o);
      @(negedge clk); guard++;
    end
    chk("R11 old line total kept until frame end", seen, 9);
    m_ht = 11;
    watch(72, pf, hm);
    chk("R11 new line total after frame start", hm, 11);
  endtask

  task automatic t_stop_reload();
    int pf, hm;
    put_ctrl(0, 1);
    watch(20, pf, hm);
    chk("R2 no prefetch after stop", pf, 0);
    m_ht = 9;
    wr(A_LIM0 + L_HTOT, m_ht);
    put_ctrl(1, 1);
    watch(60, pf, hm);
    chk("R11 stopped write in force at start", hm, 9);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle();
    t_run();
    t_polarity();
    t_sync_off();
    t_rgb();
    t_blank();
    t_shadow();
    t_stop_reload();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule